// File: doc/BRIEF.md
# Branch and PC-Relative Target Unit

This unit resolves the control-flow outcome of one instruction per cycle for a small register-machine core. Given the instruction word, its address, its length (16 or 32 bits), the T condition bit, one register operand and the current link register, it produces the next program counter, a taken flag, an optional link-register write carrying the return address, and optional writes of the constant-table or offset-table base register.

All displacements count from the address of the instruction that follows the branch. Branch displacements count 16-bit units. Table-base displacements count 64-bit units, and the result is aligned down to a 64-bit boundary. Fetch, the register file and memory access belong to the surrounding pipeline. The unit only computes and registers its results, one cycle after the instruction is presented.

Top module: `bt_unit`

## Requirements
- R1: While rst_ni is low, every output is zero.
- R2: Outputs appear one clock after the instruction is presented with valid_i high, and valid_o copies that valid_i. A cycle with valid_i low yields valid_o, taken_o, lr_we_o, ct_we_o and ot_we_o low and all data outputs zero.
- R3: With ilen_i=0 the instruction is instr_i[15:0], and next = pc_i+2. A top byte of 0x64..0x67 is an unconditional branch to next + 2*d, where d is instr_i[9:0] as a signed 10-bit value.
- R4: A top byte of 0x68..0x6B branches when t_i=1, and 0x6C..0x6F branches when t_i=0. Both use the same target rule as R3.
- R5: With ilen_i=1, next = pc_i+4. When instr_i[31:24]=0xE3, field instr_i[23:21] selects the form: 1 branch, 2 call, 4 branch if t_i=1, 5 branch if t_i=0. The target is next + 2*d, where d is instr_i[20:0] as a signed 21-bit value.
- R6: A call writes the link register with next: lr_we_o=1 and lr_data_o=next, with taken_o=1. The call forms are the 32-bit call (selector 2), the 16-bit absolute register call (instr[15:4]=0x287) and the 16-bit relative register call (0x289). lr_data_o is zero when no write is made.
- R7: The 16-bit register jumps are decoded from instr[15:4]. 0x286 jumps to rs_i and 0x287 calls rs_i. 0x288 jumps to next+rs_i and 0x289 calls next+rs_i.
- R8: The 16-bit word 0x29F1 returns: taken_o=1 and target_o=lr_i.
- R9: Table-base loads set ct_we_o or ot_we_o with tbl_data_o = (next + 8*(d+1)) with bits [2:0] cleared, taken_o=0 and target_o=next. The constant-table base is loaded by 16-bit top byte 0x60..0x63 (d = instr[9:0] unsigned) or by 32-bit selector 0. The offset-table base is loaded by 32-bit selector 3 (d signed 21-bit). tbl_data_o is zero when no write is made.
- R10: Any other encoding produces taken_o=0, target_o=next and no writes. This covers 32-bit words while ilen_i=0, instr_i[31:16] under ilen_i=0, and 32-bit selectors 6 and 7. The upper half instr_i[31:16] has no effect while ilen_i=0.
- R11: A conditional branch whose condition fails gives taken_o=0 and target_o=next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction; 16-bit forms in [15:0], 32-bit first word in [31:16] |
| ilen_i | input | 1 | 0: 16-bit instruction, 1: 32-bit |
| pc_i | input | ADDR_W | Address of the instruction |
| t_i | input | 1 | Condition bit |
| rs_i | input | ADDR_W | Register operand for register jumps |
| lr_i | input | ADDR_W | Current link register |
| valid_o | output | 1 | Registered result valid |
| taken_o | output | 1 | Control transfer taken |
| target_o | output | ADDR_W | Next program counter |
| lr_we_o | output | 1 | Link register write |
| lr_data_o | output | ADDR_W | Return address |
| ct_we_o | output | 1 | Constant-table base write |
| ot_we_o | output | 1 | Offset-table base write |
| tbl_data_o | output | ADDR_W | Aligned table base value |

## Verification
The bench builds the unit with ADDR_W=16, narrower than the 21-bit long displacement. At that width, far forward and backward displacements, register-relative sums and table offsets wrap around the address space. This checks that sign extension, truncation and the low-bit alignment hold when the arithmetic overflows. With 16-bit addresses, random program counters near both ends of the space hit these wrap cases often.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int SHORT_DISP_W = 10;
  localparam int LONG_DISP_W  = 21;
  localparam int DISP_W       = LONG_DISP_W + 1;
  localparam int TBL_UNIT_B   = 8;
  localparam int BR_UNIT_B    = 2;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_BR,
    OP_BR_T,
    OP_BR_F,
    OP_CALL,
    OP_JMP_ABS,
    OP_CALL_ABS,
    OP_JMP_REL,
    OP_CALL_REL,
    OP_RET,
    OP_CT_BASE,
    OP_OT_BASE
  } bt_op_e;

  typedef struct packed {
    bt_op_e                    op;
    logic signed [DISP_W-1:0]  disp;
  } bt_dec_t;
endpackage

// File: rtl/bt_decode.sv
module bt_decode
  import bt_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic        long_i,
  output bt_dec_t     dec_o
);
  logic [15:0] w_lo;
  logic [2:0]  sel;

  assign w_lo = instr_i[15:0];
  assign sel  = instr_i[23:21];

  always_comb begin
    dec_o.op   = OP_NONE;
    dec_o.disp = '0;
    if (long_i) begin
      dec_o.disp = DISP_W'($signed(instr_i[LONG_DISP_W-1:0]));
      if (instr_i[31:24] == 8'hE3) begin
        unique case (sel)
          3'd0:    dec_o.op = OP_CT_BASE;
          3'd1:    dec_o.op = OP_BR;
          3'd2:    dec_o.op = OP_CALL;
          3'd3:    dec_o.op = OP_OT_BASE;
          3'd4:    dec_o.op = OP_BR_T;
          3'd5:    dec_o.op = OP_BR_F;
          default: dec_o.op = OP_NONE;
        endcase
      end
    end else begin
      unique case (w_lo[15:10])
        6'b011000: begin
          dec_o.op   = OP_CT_BASE;
          dec_o.disp = DISP_W'(w_lo[SHORT_DISP_W-1:0]);
        end
        6'b011001: begin
          dec_o.op   = OP_BR;
          dec_o.disp = DISP_W'($signed(w_lo[SHORT_DISP_W-1:0]));
        end
        6'b011010: begin
          dec_o.op   = OP_BR_T;
          dec_o.disp = DISP_W'($signed(w_lo[SHORT_DISP_W-1:0]));
        end
        6'b011011: begin
          dec_o.op   = OP_BR_F;
          dec_o.disp = DISP_W'($signed(w_lo[SHORT_DISP_W-1:0]));
        end
        default: begin
          unique case (w_lo[15:4])
            12'h286: dec_o.op = OP_JMP_ABS;
            12'h287: dec_o.op = OP_CALL_ABS;
            12'h288: dec_o.op = OP_JMP_REL;
            12'h289: dec_o.op = OP_CALL_REL;
            12'h29F: dec_o.op = (w_lo[3:0] == 4'h1) ? OP_RET : OP_NONE;
            default: dec_o.op = OP_NONE;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/bt_target.sv
module bt_target
  import bt_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0]        pc_i,
  input  logic                     long_i,
  input  logic signed [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0]        rs_i,
  output logic [ADDR_W-1:0]        next_o,
  output logic [ADDR_W-1:0]        br_o,
  output logic [ADDR_W-1:0]        rel_o,
  output logic [ADDR_W-1:0]        tbl_o
);
  localparam int BR_SH  = $clog2(BR_UNIT_B);
  localparam int TBL_SH = $clog2(TBL_UNIT_B);

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] tbl_raw;

  assign disp_ext = ADDR_W'(disp_i);
  assign next_o   = pc_i + (long_i ? ADDR_W'(4) : ADDR_W'(2));
  assign br_o     = next_o + (disp_ext << BR_SH);
  assign rel_o    = next_o + rs_i;
  assign tbl_raw  = next_o + ((disp_ext + ADDR_W'(1)) << TBL_SH);

  generate
    if (ADDR_W > TBL_SH) begin : g_align
      assign tbl_o = {tbl_raw[ADDR_W-1:TBL_SH], {TBL_SH{1'b0}}};
    end else begin : g_tiny
      assign tbl_o = '0;
    end
  endgenerate
endmodule

// File: rtl/bt_resolve.sv
module bt_resolve
  import bt_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  bt_op_e            op_i,
  input  logic              t_i,
  input  logic [ADDR_W-1:0] next_i,
  input  logic [ADDR_W-1:0] br_i,
  input  logic [ADDR_W-1:0] rel_i,
  input  logic [ADDR_W-1:0] tbl_i,
  input  logic [ADDR_W-1:0] rs_i,
  input  logic [ADDR_W-1:0] lr_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              lr_we_o,
  output logic [ADDR_W-1:0] lr_data_o,
  output logic              ct_we_o,
  output logic              ot_we_o,
  output logic [ADDR_W-1:0] tbl_data_o
);
  always_comb begin
    taken_o  = 1'b0;
    target_o = next_i;
    lr_we_o  = 1'b0;
    ct_we_o  = 1'b0;
    ot_we_o  = 1'b0;
    unique case (op_i)
      OP_BR:       begin taken_o = 1'b1; target_o = br_i; end
      OP_BR_T:     if (t_i)  begin taken_o = 1'b1; target_o = br_i; end
      OP_BR_F:     if (!t_i) begin taken_o = 1'b1; target_o = br_i; end
      OP_CALL:     begin taken_o = 1'b1; target_o = br_i;  lr_we_o = 1'b1; end
      OP_JMP_ABS:  begin taken_o = 1'b1; target_o = rs_i; end
      OP_CALL_ABS: begin taken_o = 1'b1; target_o = rs_i;  lr_we_o = 1'b1; end
      OP_JMP_REL:  begin taken_o = 1'b1; target_o = rel_i; end
      OP_CALL_REL: begin taken_o = 1'b1; target_o = rel_i; lr_we_o = 1'b1; end
      OP_RET:      begin taken_o = 1'b1; target_o = lr_i; end
      OP_CT_BASE:  ct_we_o = 1'b1;
      OP_OT_BASE:  ot_we_o = 1'b1;
      default:     ;
    endcase
  end

  assign lr_data_o  = lr_we_o ? next_i : '0;
  assign tbl_data_o = (ct_we_o || ot_we_o) ? tbl_i : '0;
endmodule

// File: rtl/bt_unit.sv
module bt_unit
  import bt_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic              ilen_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              t_i,
  input  logic [ADDR_W-1:0] rs_i,
  input  logic [ADDR_W-1:0] lr_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              lr_we_o,
  output logic [ADDR_W-1:0] lr_data_o,
  output logic              ct_we_o,
  output logic              ot_we_o,
  output logic [ADDR_W-1:0] tbl_data_o
);
  bt_dec_t           dec;
  logic [ADDR_W-1:0] next_a, br_a, rel_a, tbl_a;
  logic              taken_d, lr_we_d, ct_we_d, ot_we_d;
  logic [ADDR_W-1:0] target_d, lr_data_d, tbl_data_d;

  bt_decode i_decode (
    .instr_i (instr_i),
    .long_i  (ilen_i),
    .dec_o   (dec)
  );

  bt_target #(.ADDR_W(ADDR_W)) i_target (
    .pc_i   (pc_i),
    .long_i (ilen_i),
    .disp_i (dec.disp),
    .rs_i   (rs_i),
    .next_o (next_a),
    .br_o   (br_a),
    .rel_o  (rel_a),
    .tbl_o  (tbl_a)
  );

  bt_resolve #(.ADDR_W(ADDR_W)) i_resolve (
    .op_i       (dec.op),
    .t_i        (t_i),
    .next_i     (next_a),
    .br_i       (br_a),
    .rel_i      (rel_a),
    .tbl_i      (tbl_a),
    .rs_i       (rs_i),
    .lr_i       (lr_i),
    .taken_o    (taken_d),
    .target_o   (target_d),
    .lr_we_o    (lr_we_d),
    .lr_data_o  (lr_data_d),
    .ct_we_o    (ct_we_d),
    .ot_we_o    (ot_we_d),
    .tbl_data_o (tbl_data_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      taken_o    <= 1'b0;
      target_o   <= '0;
      lr_we_o    <= 1'b0;
      lr_data_o  <= '0;
      ct_we_o    <= 1'b0;
      ot_we_o    <= 1'b0;
      tbl_data_o <= '0;
    end else if (!valid_i) begin
      valid_o    <= 1'b0;
      taken_o    <= 1'b0;
      target_o   <= '0;
      lr_we_o    <= 1'b0;
      lr_data_o  <= '0;
      ct_we_o    <= 1'b0;
      ot_we_o    <= 1'b0;
      tbl_data_o <= '0;
    end else begin
      valid_o    <= 1'b1;
      taken_o    <= taken_d;
      target_o   <= target_d;
      lr_we_o    <= lr_we_d;
      lr_data_o  <= lr_data_d;
      ct_we_o    <= ct_we_d;
      ot_we_o    <= ot_we_d;
      tbl_data_o <= tbl_data_d;
    end
  end
endmodule

// File: rtl/bt_unit_chk.sv
module bt_unit_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [31:0]       instr_i,
  input logic              ilen_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] lr_i,
  input logic              valid_o,
  input logic              taken_o,
  input logic [ADDR_W-1:0] target_o,
  input logic              lr_we_o,
  input logic [ADDR_W-1:0] lr_data_o,
  input logic              ct_we_o,
  input logic              ot_we_o,
  input logic [ADDR_W-1:0] tbl_data_o
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!taken_o && !lr_we_o && !ct_we_o && !ot_we_o));

  a_r6_link_is_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_we_o |-> (lr_data_o == ($past(pc_i) + ($past(ilen_i) ? ADDR_W'(4) : ADDR_W'(2)))));

  a_r6_link_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_we_o |-> taken_o);

  a_r9_tbl_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ct_we_o || ot_we_o) |-> (tbl_data_o[2:0] == 3'b000 && !taken_o));

  a_r9_one_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ct_we_o && ot_we_o));

  a_r8_ret_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && !$past(ilen_i) && $past(instr_i[15:0]) == 16'h29F1)
      |-> (taken_o && target_o == $past(lr_i)));

  a_r11_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !taken_o) |->
      (target_o == ($past(pc_i) + ($past(ilen_i) ? ADDR_W'(4) : ADDR_W'(2)))));
endmodule

bind bt_unit bt_unit_chk #(.ADDR_W(ADDR_W)) i_bt_unit_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .instr_i    (instr_i),
  .ilen_i     (ilen_i),
  .pc_i       (pc_i),
  .lr_i       (lr_i),
  .valid_o    (valid_o),
  .taken_o    (taken_o),
  .target_o   (target_o),
  .lr_we_o    (lr_we_o),
  .lr_data_o  (lr_data_o),
  .ct_we_o    (ct_we_o),
  .ot_we_o    (ot_we_o),
  .tbl_data_o (tbl_data_o)
);

// File: tb/test_bt_unit.sv
module test_bt_unit;
  localparam int AW = 16;

  typedef struct packed {
    logic          v;
    logic          tk;
    logic [AW-1:0] tg;
    logic          lw;
    logic [AW-1:0] ld;
    logic          c;
    logic          o;
    logic [AW-1:0] tb;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [31:0]   instr = '0;
  logic          ilen = 1'b0;
  logic [AW-1:0] pc = '0;
  logic          tbit = 1'b0;
  logic [AW-1:0] rs = '0;
  logic [AW-1:0] lr = '0;
  logic          valid_o, taken_o, lr_we_o, ct_we_o, ot_we_o;
  logic [AW-1:0] target_o, lr_data_o, tbl_data_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  bt_unit #(.ADDR_W(AW)) i_bt_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr), .ilen_i(ilen),
    .pc_i(pc), .t_i(tbit), .rs_i(rs), .lr_i(lr),
    .valid_o(valid_o), .taken_o(taken_o), .target_o(target_o), .lr_we_o(lr_we_o),
    .lr_data_o(lr_data_o), .ct_we_o(ct_we_o), .ot_we_o(ot_we_o), .tbl_data_o(tbl_data_o)
  );

  function automatic exp_t model(input logic [31:0] ins, input logic lng, input logic [AW-1:0] p,
                                 input logic t, input logic [AW-1:0] r, input logic [AW-1:0] l,
                                 input logic v, output string tag);
    exp_t e = '0;
    int nx, d;
    logic [15:0] w;
    tag = "R2";
    if (!v) return e;
    e.v  = 1'b1;
    nx   = int'(p) + (lng ? 4 : 2);
    e.tg = AW'(nx);
    tag  = "R10";
    if (lng) begin
      if (ins[31:24] == 8'hE3) begin
        d = int'(ins[20:0]);
        if (d >= (1 << 20)) d -= (1 << 21);
        case (ins[23:21])
          3'd1: begin e.tk = 1; e.tg = AW'(nx + 2*d); tag = "R5"; end
          3'd2: begin e.tk = 1; e.tg = AW'(nx + 2*d); e.lw = 1; e.ld = AW'(nx); tag = "R6"; end
          3'd4: if (t)  begin e.tk = 1; e.tg = AW'(nx + 2*d); tag = "R5"; end else tag = "R11";
          3'd5: if (!t) begin e.tk = 1; e.tg = AW'(nx + 2*d); tag = "R5"; end else tag = "R11";
          3'd0: begin e.c = 1; e.tb = AW'(nx + 8*(d+1)) & ~AW'(7); tag = "R9"; end
          3'd3: begin e.o = 1; e.tb = AW'(nx + 8*(d+1)) & ~AW'(7); tag = "R9"; end
          default: ;
        endcase
      end
    end else begin
      w = ins[15:0];
      d = int'(w[9:0]);
      if (w[15:8] >= 8'h60 && w[15:8] <= 8'h63) begin
        e.c = 1; e.tb = AW'(nx + 8*(d+1)) & ~AW'(7); tag = "R9";
      end else begin
        if (d >= 512) d -= 1024;
        if (w[15:8] >= 8'h64 && w[15:8] <= 8'h67) begin
          e.tk = 1; e.tg = AW'(nx + 2*d); tag = "R3";
        end else if (w[15:8] >= 8'h68 && w[15:8] <= 8'h6B) begin
          if (t) begin e.tk = 1; e.tg = AW'(nx + 2*d); tag = "R4"; end else tag = "R11";
        end else if (w[15:8] >= 8'h6C && w[15:8] <= 8'h6F) begin
          if (!t) begin e.tk = 1; e.tg = AW'(nx + 2*d); tag = "R4"; end else tag = "R11";
        end else if (w[15:4] == 12'h286) begin
          e.tk = 1; e.tg = r; tag = "R7";
        end else if (w[15:4] == 12'h287) begin
          e.tk = 1; e.tg = r; e.lw = 1; e.ld = AW'(nx); tag = "R7";
        end else if (w[15:4] == 12'h288) begin
          e.tk = 1; e.tg = AW'(nx + int'(r)); tag = "R7";
        end else if (w[15:4] == 12'h289) begin
          e.tk = 1; e.tg = AW'(nx + int'(r)); e.lw = 1; e.ld = AW'(nx); tag = "R6";
        end else if (w == 16'h29F1) begin
          e.tk = 1; e.tg = l; tag = "R8";
        end
      end
    end
    return e;
  endfunction

  task automatic cmp(input string tag, input string fld, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, fld, act, exp);
    end
  endtask

  task automatic check_head();
    exp_t  e;
    string tg;
    if (exp_q.size() == 0) return;
    e  = exp_q.pop_front();
    tg = tag_q.pop_front();
    cmp("R2", "valid", AW'(valid_o), AW'(e.v));
    cmp(tg, "taken", AW'(taken_o), AW'(e.tk));
    cmp(tg, "target", target_o, e.tg);
    cmp(tg, "lr_we", AW'(lr_we_o), AW'(e.lw));
    cmp(tg, "lr_data", lr_data_o, e.ld);
    cmp(tg, "ct_we", AW'(ct_we_o), AW'(e.c));
    cmp(tg, "ot_we", AW'(ot_we_o), AW'(e.o));
    cmp(tg, "tbl_data", tbl_data_o, e.tb);
  endtask

  task automatic step(input logic v, input logic [31:0] ins, input logic lng,
                      input logic [AW-1:0] p, input logic t,
                      input logic [AW-1:0] r, input logic [AW-1:0] l);
    string tg;
    exp_t  e;
    @(negedge clk);
    check_head();
    valid = v; instr = ins; ilen = lng; pc = p; tbit = t; rs = r; lr = l;
    e = model(ins, lng, p, t, r, l, v, tg);
    exp_q.push_back(e);
    tag_q.push_back(tg);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    cmp("R1", "valid", AW'(valid_o), '0);
    cmp("R1", "taken", AW'(taken_o), '0);
    cmp("R1", "target", target_o, '0);
    cmp("R1", "writes", AW'({lr_we_o, ct_we_o, ot_we_o}), '0);
    cmp("R1", "data", lr_data_o | tbl_data_o, '0);
    rst_n = 1'b1;

    // R3 forward / backward, R10 upper half ignored
    step(1, 32'hFFFF_6405, 0, 16'h0100, 0, 16'h0, 16'h0);
    step(1, 32'h1234_67FF, 0, 16'h0100, 0, 16'h0, 16'h0);
    step(1, 32'h0000_6600, 0, 16'h0010, 1, 16'h0, 16'h0);
    // R4 / R11
    step(1, 32'h0000_6810, 0, 16'h0200, 1, 16'h0, 16'h0);
    step(1, 32'h0000_6810, 0, 16'h0200, 0, 16'h0, 16'h0);
    step(1, 32'h0000_6C10, 0, 16'h0200, 0, 16'h0, 16'h0);
    step(1, 32'h0000_6C10, 0, 16'h0200, 1, 16'h0, 16'h0);
    step(0, 32'h0000_6405, 0, 16'h0100, 0, 16'h0, 16'h0);  // R2 idle
    // R5 32-bit forms, far displacements wrap
    step(1, 32'hE320_0010, 1, 16'h0400, 0, 16'h0, 16'h0);
    step(1, 32'hE33F_FFFE, 1, 16'h0400, 0, 16'h0, 16'h0);
    step(1, 32'hE380_0008, 1, 16'h0400, 1, 16'h0, 16'h0);
    step(1, 32'hE3A0_0008, 1, 16'h0400, 1, 16'h0, 16'h0);
    step(1, 32'hE3B0_0000, 1, 16'hFFF0, 0, 16'h0, 16'h0);
    // R6 call
    step(1, 32'hE340_0020, 1, 16'h1000, 0, 16'h0, 16'h0);
    // R7 register jumps
    step(1, 32'h0000_2863, 0, 16'h2000, 0, 16'hBEEE, 16'h0);
    step(1, 32'h0000_2874, 0, 16'h2000, 0, 16'h3002, 16'h0);
    step(1, 32'h0000_2885, 0, 16'hFFFE, 0, 16'h0010, 16'h0);
    step(1, 32'h0000_2896, 0, 16'h2000, 0, 16'hFFFC, 16'h0);
    // R8 return
    step(1, 32'h0000_29F1, 0, 16'h3000, 0, 16'h0, 16'h4444);
    step(1, 32'h0000_29F0, 0, 16'h3000, 0, 16'h0, 16'h4444);  // R10 nop-like
    // R9 table bases
    step(1, 32'h0000_6000, 0, 16'h0102, 0, 16'h0, 16'h0);
    step(1, 32'h0000_63FF, 0, 16'h0106, 0, 16'h0, 16'h0);
    step(1, 32'hE31F_FFFF, 1, 16'h0502, 0, 16'h0, 16'h0);
    step(1, 32'hE360_0003, 1, 16'h0506, 0, 16'h0, 16'h0);
    // R10 32-bit word under short length, unused selectors
    step(1, 32'h0000_E320, 0, 16'h0600, 0, 16'h0, 16'h0);
    step(1, 32'hE3C0_0010, 1, 16'h0600, 0, 16'h0, 16'h0);
    step(1, 32'hE3E0_0010, 1, 16'h0600, 1, 16'h0, 16'h0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ins;
      logic        lng;
      int k;
      k   = $urandom_range(0, 5);
      ins = $urandom;
      lng = 1'b0;
      case (k)
        0: ins[15:0] = {6'($urandom_range(24, 27)), 10'($urandom)};
        1: ins[15:0] = {12'(12'h286 + $urandom_range(0, 3)), 4'($urandom)};
        2: ins[15:0] = 16'h29F1;
        3: begin ins[31:21] = {8'hE3, 3'($urandom_range(0, 7))}; lng = 1'b1; end
        4: lng = 1'($urandom);
        default: ;
      endcase
      step(1'($urandom_range(0, 7) != 0), ins, lng, AW'($urandom), 1'($urandom),
           AW'($urandom), AW'($urandom));
    end
    step(0, '0, 0, '0, 0, '0, '0);
    @(negedge clk);
    check_head();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule